// File: doc/BRIEF.md
# Boot Strap Latch and Boot Window Decoder

This block reads two boot-select strap pins while system reset is held and keeps their value once reset is released. While reset is active it turns the pins' output drivers off and enables their pull-ups, so a pin left open reads as 1. After reset it gives the pins back to their other shared function by passing that function's output enables through.

The latched strap sets the reset defaults of a 32-bit configuration register. A read-only field holds the captured strap. A writable two-bit boot-location field and a writable pin-group select bit start from the strap value. The pin-group select routes a shared pin group either to a flash controller or to a storage-disk controller. The boot-location field steers one fixed 16 KiB high-memory window to one of three boot chip selects. When that field holds its reserved code, the block asserts no chip select and sets a sticky error flag instead.

Strap and location codes: 00 = LPC ROM, 01 = reserved, 10 = NOR flash on the shared pins, 11 = firmware hub.

Top module: `bootstrap_cfg`

## Requirements
- R1: While rst_n is low, pad_pu_o is 2'b11 and pad_oe_o is 2'b00. While rst_n is high, pad_pu_o is 2'b00 and pad_oe_o equals func_oe_i.
- R2: Register bits 9:8 read the strap pad value that was held steady for at least three clocks before rst_n rose. Writes to these bits are ignored. Pad changes after reset leave them unchanged until the next reset.
- R3: Register bits 11:10 (boot location) reset to the latched strap value and afterwards take bits 11:10 of each write.
- R4: Register bit 0 (pin-group select) resets to 1 when the strap is 10 and to 0 for any other strap. It takes bit 0 of each write. pin_grp_flash_o always equals this bit, where 1 means the flash controller and 0 means the disk controller.
- R5: Register bits 31:12 always read 0, and writes to them have no effect.
- R6: Register bits 7:1 reset to 0 and read back the last value written.
- R7: When bus_vld_i is high and bus_addr_i lies in F00F0000h..F00F3FFFh inclusive, exactly one chip select is asserted, chosen by the location code: 00 gives cs_lpc_rom_o, 10 gives cs_flash_o and 11 gives cs_fwh_o. Outside the window, or when bus_vld_i is low, no chip select is asserted. The chip selects follow their inputs in the same cycle.
- R8: A valid access in the window while the location code is 01 asserts no chip select, and boot_err_o goes high at the next clock edge. boot_err_o then stays high until reset, which clears it to 0.
- R9: A write on reg_wr_i takes effect at the clock edge. From that edge on, reg_rdata_o (combinational) and the chip-select decode both use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, sampled synchronously |
| strap_pad_i | input | 2 | Input values of the two strap pins |
| func_oe_i | input | 2 | Output enables from the pins' other shared function |
| pad_oe_o | output | 2 | Output driver enables to the strap pins |
| pad_pu_o | output | 2 | Pull-up enables to the strap pins |
| reg_wr_i | input | 1 | Configuration register write strobe |
| reg_wdata_i | input | 32 | Configuration register write data |
| reg_rdata_o | output | 32 | Configuration register read data |
| pin_grp_flash_o | output | 1 | Shared pin group select: 1 flash, 0 disk controller |
| bus_addr_i | input | 32 | Access address |
| bus_vld_i | input | 1 | Access valid |
| cs_lpc_rom_o | output | 1 | LPC ROM boot chip select |
| cs_flash_o | output | 1 | Flash boot chip select |
| cs_fwh_o | output | 1 | Firmware hub boot chip select |
| boot_err_o | output | 1 | Sticky flag for an access to the window with the reserved location |

## Verification
The assertions assume that the strap pads stay steady for the last few clocks of each reset. They also assume that no register write is attempted in a cycle with rst_n low, because reset takes priority and such a write would be lost.

The bench sets each strap value before asserting reset. It holds reset for five clocks and changes the pads only after release or in a later reset. Writes and accesses are issued only while out of reset. The window bounds and the addresses one past each bound are always included next to the random addresses.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
   localparam int STRAP_W = 2;

   typedef enum logic [STRAP_W-1:0] {
      LOC_LPC   = 2'b00,
      LOC_RSVD  = 2'b01,
      LOC_FLASH = 2'b10,
      LOC_FWH   = 2'b11
   } boot_loc_e;

   // register field positions (software-visible layout)
   localparam int F_PGSEL    = 0;
   localparam int F_RSV_LO   = 1;
   localparam int F_RSV_HI   = 7;
   localparam int F_STRAP_LO = 8;
   localparam int F_LOC_LO   = 10;
   localparam int F_USED_W   = 12;
   localparam int RSV_W      = F_RSV_HI - F_RSV_LO + 1;

   typedef struct packed {
      logic                  fwh;
      logic                  flash;
      logic                  lpc_rom;
   } boot_cs_t;
endpackage

// File: rtl/bsl_strap_sync.sv
module bsl_strap_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) chain[s] <= din;
         end else begin : g_next
            always_ff @(posedge clk) chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/bsl_strap_pad.sv
module bsl_strap_pad #(
   parameter int WIDTH = 2
) (
   input  logic             rst_n,
   input  logic [WIDTH-1:0] func_oe,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pu
);
   generate
      for (genvar p = 0; p < WIDTH; p++) begin : g_pin
         assign pad_oe[p] = rst_n & func_oe[p];
         assign pad_pu[p] = ~rst_n;
      end
   endgenerate
endmodule

// File: rtl/bsl_cfg_reg.sv
module bsl_cfg_reg
   import bsl_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STRAP_W-1:0]  strap_sync,
   input  logic                wr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output boot_loc_e           loc,
   output logic                pgsel
);
   logic [STRAP_W-1:0] strap_q;
   logic [RSV_W-1:0]   rsv_q;
   boot_loc_e          loc_q;
   logic               pg_q;
   logic               unused_wbits;

   assign unused_wbits = ^{wdata[DATA_W-1:F_USED_W], wdata[F_STRAP_LO +: STRAP_W]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strap_q <= strap_sync;
         loc_q   <= boot_loc_e'(strap_sync);
         rsv_q   <= '0;
         pg_q    <= (strap_sync == LOC_FLASH);
      end else if (wr) begin
         loc_q   <= boot_loc_e'(wdata[F_LOC_LO +: STRAP_W]);
         rsv_q   <= wdata[F_RSV_HI:F_RSV_LO];
         pg_q    <= wdata[F_PGSEL];
      end
   end

   always_comb begin
      rdata                         = '0;
      rdata[F_LOC_LO +: STRAP_W]    = loc_q;
      rdata[F_STRAP_LO +: STRAP_W]  = strap_q;
      rdata[F_RSV_HI:F_RSV_LO]      = rsv_q;
      rdata[F_PGSEL]                = pg_q;
   end

   assign loc   = loc_q;
   assign pgsel = pg_q;
endmodule

// File: rtl/bsl_window_dec.sv
module bsl_window_dec
   import bsl_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF00F_0000,
   parameter int                WIN_LOG2 = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              vld,
   input  boot_loc_e         loc,
   output boot_cs_t          cs,
   output logic              err
);
   localparam logic [ADDR_W-1:0] WIN_MASK =
      ~((ADDR_W'(1) << WIN_LOG2) - ADDR_W'(1));

   logic in_win;
   logic hit;
   logic err_q;

   generate
      if (WIN_LOG2 == 0) begin : g_exact
         assign in_win = (addr == WIN_BASE);
      end else begin : g_masked
         assign in_win = ((addr & WIN_MASK) == WIN_BASE);
      end
   endgenerate

   assign hit = vld & in_win;

   always_comb begin
      cs = '0;
      if (hit) begin
         unique case (loc)
            LOC_LPC:   cs.lpc_rom = 1'b1;
            LOC_FLASH: cs.flash   = 1'b1;
            LOC_FWH:   cs.fwh     = 1'b1;
            default:   cs         = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       err_q <= 1'b0;
      else if (hit && loc == LOC_RSVD)  err_q <= 1'b1;
   end

   assign err = err_q;
endmodule

// File: rtl/bootstrap_cfg.sv
module bootstrap_cfg
   import bsl_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter int                ADDR_W      = 32,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] WIN_BASE    = 32'hF00F_0000,
   parameter int                WIN_LOG2    = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        strap_pad_i,
   input  logic [1:0]        func_oe_i,
   output logic [1:0]        pad_oe_o,
   output logic [1:0]        pad_pu_o,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              pin_grp_flash_o,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_vld_i,
   output logic              cs_lpc_rom_o,
   output logic              cs_flash_o,
   output logic              cs_fwh_o,
   output logic              boot_err_o
);
   localparam logic [ADDR_W-1:0] WIN_LOW_BITS =
      (ADDR_W'(1) << WIN_LOG2) - ADDR_W'(1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bootstrap_cfg: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < F_USED_W) begin : g_bad_dw
         $error("bootstrap_cfg: DATA_W too narrow for register fields");
      end
      if (WIN_LOG2 >= ADDR_W) begin : g_bad_win
         $error("bootstrap_cfg: WIN_LOG2 must be below ADDR_W");
      end
      if ((WIN_BASE & WIN_LOW_BITS) != '0) begin : g_bad_base
         $error("bootstrap_cfg: WIN_BASE not aligned to window size");
      end
   endgenerate

   logic [STRAP_W-1:0] strap_sync;
   boot_loc_e          loc;
   logic               pgsel;
   boot_cs_t           cs;

   bsl_strap_pad #(.WIDTH(STRAP_W)) u_pad (
      .rst_n   (rst_n),
      .func_oe (func_oe_i),
      .pad_oe  (pad_oe_o),
      .pad_pu  (pad_pu_o)
   );

   bsl_strap_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .din  (strap_pad_i),
      .dout (strap_sync)
   );

   bsl_cfg_reg #(.DATA_W(DATA_W)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_sync (strap_sync),
      .wr         (reg_wr_i),
      .wdata      (reg_wdata_i),
      .rdata      (reg_rdata_o),
      .loc        (loc),
      .pgsel      (pgsel)
   );

   bsl_window_dec #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr_i),
      .vld   (bus_vld_i),
      .loc   (loc),
      .cs    (cs),
      .err   (boot_err_o)
   );

   assign pin_grp_flash_o = pgsel;
   assign cs_lpc_rom_o    = cs.lpc_rom;
   assign cs_flash_o      = cs.flash;
   assign cs_fwh_o        = cs.fwh;
endmodule

// File: rtl/bsl_checker.sv
module bsl_checker #(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF00F_0000,
   parameter int                WIN_LOG2 = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        func_oe_i,
   input logic [1:0]        pad_oe_o,
   input logic [1:0]        pad_pu_o,
   input logic              reg_wr_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              pin_grp_flash_o,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic              bus_vld_i,
   input logic              cs_lpc_rom_o,
   input logic              cs_flash_o,
   input logic              cs_fwh_o,
   input logic              boot_err_o
);
   localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + ((ADDR_W'(1) << WIN_LOG2) - ADDR_W'(1));

   logic win_acc;
   logic unused_rsv;
   assign win_acc    = bus_vld_i && bus_addr_i >= WIN_BASE && bus_addr_i <= WIN_LAST;
   assign unused_rsv = ^reg_rdata_o[7:1];

   // R1
   pad_reset_chk: assert property (@(posedge clk)
      !rst_n |-> (pad_pu_o == 2'b11 && pad_oe_o == 2'b00));

   // R1
   pad_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pad_pu_o == 2'b00 && pad_oe_o == func_oe_i);

   // R2
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(reg_rdata_o[9:8]));

   // R4
   pgsel_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_grp_flash_o == reg_rdata_o[0]);

   // R5
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata_o[DATA_W-1:12] == '0);

   // R7
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cs_lpc_rom_o, cs_flash_o, cs_fwh_o}));

   // R7
   cs_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_acc |-> {cs_lpc_rom_o, cs_flash_o, cs_fwh_o} == 3'b000);

   // R7
   cs_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && reg_rdata_o[11:10] != 2'b01) |-> $countones({cs_lpc_rom_o, cs_flash_o, cs_fwh_o}) == 1);

   // R8
   rsvd_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && reg_rdata_o[11:10] == 2'b01) |-> {cs_lpc_rom_o, cs_flash_o, cs_fwh_o} == 3'b000);

   // R8
   rsvd_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && reg_rdata_o[11:10] == 2'b01) |=> boot_err_o);

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_err_o |=> boot_err_o);

   // R9
   no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(reg_wr_i)) |-> $stable(reg_rdata_o));
endmodule

bind bootstrap_cfg bsl_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .func_oe_i       (func_oe_i),
   .pad_oe_o        (pad_oe_o),
   .pad_pu_o        (pad_pu_o),
   .reg_wr_i        (reg_wr_i),
   .reg_rdata_o     (reg_rdata_o),
   .pin_grp_flash_o (pin_grp_flash_o),
   .bus_addr_i      (bus_addr_i),
   .bus_vld_i       (bus_vld_i),
   .cs_lpc_rom_o    (cs_lpc_rom_o),
   .cs_flash_o      (cs_flash_o),
   .cs_fwh_o        (cs_fwh_o),
   .boot_err_o      (boot_err_o)
);

// File: tb/sim_bootstrap_cfg.sv
module sim_bootstrap_cfg;
   localparam int          CLK_PERIOD = 10;
   localparam int          WD_CYCLES  = 50000;
   localparam logic [31:0] W_LO       = 32'hF00F_0000;
   localparam logic [31:0] W_HI       = 32'hF00F_3FFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  strap_pad_i = 2'b11;
   logic [1:0]  func_oe_i = 2'b00;
   logic [1:0]  pad_oe_o, pad_pu_o;
   logic        reg_wr_i = 1'b0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        pin_grp_flash_o;
   logic [31:0] bus_addr_i = '0;
   logic        bus_vld_i = 1'b0;
   logic        cs_lpc_rom_o, cs_flash_o, cs_fwh_o, boot_err_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // reference model state
   logic [1:0] m_strap, m_loc;
   logic [6:0] m_rsv;
   logic       m_pg, m_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   bootstrap_cfg u0 (
      .clk(clk), .rst_n(rst_n), .strap_pad_i(strap_pad_i), .func_oe_i(func_oe_i),
      .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o), .reg_wr_i(reg_wr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .pin_grp_flash_o(pin_grp_flash_o), .bus_addr_i(bus_addr_i), .bus_vld_i(bus_vld_i),
      .cs_lpc_rom_o(cs_lpc_rom_o), .cs_flash_o(cs_flash_o), .cs_fwh_o(cs_fwh_o),
      .boot_err_o(boot_err_o)
   );

   function automatic logic [31:0] exp_rdata();
      return {20'h0, m_loc, m_strap, m_rsv, m_pg};
   endfunction

   function automatic logic [2:0] exp_cs(input logic [31:0] a, input logic v, input logic [1:0] loc);
      logic inw;
      inw = v && a >= W_LO && a <= W_HI;
      if (!inw) return 3'b000;
      case (loc)
         2'b00:   return 3'b001;
         2'b10:   return 3'b010;
         2'b11:   return 3'b100;
         default: return 3'b000;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_regs();
      chk("R2 strap field", {30'h0, reg_rdata_o[9:8]}, {30'h0, m_strap});
      chk("R3/R6/R5 rdata", reg_rdata_o, exp_rdata());
      chk("R4 pin group", {31'h0, pin_grp_flash_o}, {31'h0, m_pg});
   endtask

   task automatic do_reset(input logic [1:0] s);
      @(negedge clk);
      rst_n       = 1'b0;
      strap_pad_i = s;
      func_oe_i   = 2'b11;
      repeat (5) @(negedge clk);
      chk("R1 pull-up in reset", {30'h0, pad_pu_o}, 32'h3);
      chk("R1 oe off in reset", {30'h0, pad_oe_o}, 32'h0);
      rst_n   = 1'b1;
      m_strap = s; m_loc = s; m_rsv = '0; m_pg = (s == 2'b10); m_err = 1'b0;
      @(negedge clk);
      check_regs();
      chk("R8 err cleared by reset", {31'h0, boot_err_o}, 32'h0);
      chk("R1 pull-up off", {30'h0, pad_pu_o}, 32'h0);
      chk("R1 oe follows func", {30'h0, pad_oe_o}, {30'h0, func_oe_i});
   endtask

   task automatic do_write(input logic [31:0] d);
      reg_wr_i    = 1'b1;
      reg_wdata_i = d;
      @(negedge clk);
      reg_wr_i = 1'b0;
      m_loc = d[11:10]; m_rsv = d[7:1]; m_pg = d[0];
      check_regs();
   endtask

   task automatic do_access(input logic [31:0] a, input logic v);
      logic [2:0] e;
      bus_addr_i = a;
      bus_vld_i  = v;
      e = exp_cs(a, v, m_loc);
      #1;
      chk("R7 chip selects", {29'h0, cs_fwh_o, cs_flash_o, cs_lpc_rom_o}, {29'h0, e});
      @(negedge clk);
      bus_vld_i = 1'b0;
      if (v && a >= W_LO && a <= W_HI && m_loc == 2'b01) m_err = 1'b1;
      chk("R8 error flag", {31'h0, boot_err_o}, {31'h0, m_err});
   endtask

   function automatic logic [31:0] pick_addr();
      case ($urandom_range(0, 6))
         0: return W_LO;
         1: return W_HI;
         2: return W_LO - 1;
         3: return W_HI + 1;
         4: return W_LO + {18'h0, 14'($urandom)};
         5: return 32'hF00F_0000 ^ (32'h1 << $urandom_range(14, 31));
         default: return $urandom;
      endcase
   endfunction

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250611));
      // open pins: strap 11 -> firmware hub, disk pins
      do_reset(2'b11);
      // R5 R6 R2: write all ones, strap stays, upper bits zero
      do_write(32'hFFFF_FFFF);
      chk("R5 upper bits zero", {12'h0, reg_rdata_o[31:12]}, 32'h0);
      do_write(32'h0000_0000);
      chk("R2 strap unaffected by write", {30'h0, reg_rdata_o[9:8]}, 32'h3);
      // strap 10: flash pin group, flash chip select
      do_reset(2'b10);
      chk("R4 flash strap selects flash group", {31'h0, pin_grp_flash_o}, 32'h1);
      do_access(W_LO, 1'b1);
      do_access(W_HI, 1'b1);
      do_access(W_LO - 1, 1'b1);
      do_access(W_HI + 1, 1'b1);
      do_access(W_LO, 1'b0);
      // R2: pad change after reset has no effect
      strap_pad_i = 2'b01;
      repeat (4) @(negedge clk);
      chk("R2 latched after pad change", {30'h0, reg_rdata_o[9:8]}, 32'h2);
      // R8: reserved location
      do_write(32'h0000_0400);
      do_access(W_LO + 32'h100, 1'b1);
      chk("R8 error set", {31'h0, boot_err_o}, 32'h1);
      do_access(32'h0000_1000, 1'b1);
      // R9: switch to LPC, next access decodes new value, error stays
      do_write(32'h0000_0000);
      do_access(W_HI, 1'b1);
      chk("R8 error sticky", {31'h0, boot_err_o}, 32'h1);
      // reserved strap: location 01, disk pins
      do_reset(2'b01);
      do_access(W_LO, 1'b1);
      do_reset(2'b00);
      do_access(W_LO + 32'h2000, 1'b1);
      // constrained random phase
      for (int i = 0; i < 400; i++) begin
         case ($urandom_range(0, 9))
            0: do_reset(2'($urandom));
            1, 2: do_write($urandom);
            3: begin
               strap_pad_i = 2'($urandom);
               func_oe_i   = 2'($urandom);
               @(negedge clk);
               check_regs();
               chk("R1 oe follows func", {30'h0, pad_oe_o}, {30'h0, func_oe_i});
            end
            default: do_access(pick_addr(), ($urandom_range(0, 7) != 0));
         endcase
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule